// File: doc/BRIEF.md
# Cascadable Serial Command Register

This block receives a command word over a three-wire serial link and keeps the last completed word in a parallel holding register for downstream logic. The serial clock, serial data and an active-high frame select come in without any relation to the system clock. Each is passed through a synchronizer and then edge-detected, so all state lives in the system clock domain. While the frame select is high, every rising serial clock edge moves one bit into a shift register, most significant bit first.

A serial output follows the most significant bit of the shift register. It is updated on falling serial clock edges, so the previous contents leave the block while the new word enters. Several copies of the block can be chained by wiring each serial output to the next serial input. When the frame select falls, the shift register contents are copied into the holding register and a one-cycle update strobe is raised. Shifting alone never disturbs the held command.

Top module: `scmd_chain_reg`

## Requirements
- R1: While reset is asserted and right after it is released, the held command is zero, the update strobe is low and the serial output is low. The shift register is also cleared, so the first frame after reset shifts out zeros.
- R2: After a frame of exactly 10 serial clocks, the held command equals the 10 bits received. The first bit received lands in bit 9 and the last in bit 0.
- R3: Serial clock edges seen while the frame select is low leave the shift register unchanged. A following frame with no clocks therefore latches the same word as the previous frame.
- R4: The held command does not change while a frame is being shifted. It changes only on the cycle the update strobe is raised.
- R5: Each falling edge of the frame select raises the update strobe for exactly one system clock cycle. The held command takes its new value on that same cycle.
- R6: During a frame, the serial output presented at each rising serial clock edge is the bit the shift register held in position 9 before that edge. The old word therefore comes out most significant bit first while the new word enters.
- R7: The serial output changes only after a falling serial clock edge inside a frame, or after the frame select rises. The output is always driven.
- R8: A frame with a clock count that is not 10 latches the last 10 bits received. Bits received earlier are shifted out and lost. Positions not refilled keep their older contents.
- R9: When two blocks are chained, a frame of 20 clocks puts the first 10 bits into the far block and the last 10 bits into the near block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| sclk_i | input | 1 | Serial clock, asynchronous to clk |
| sdi_i | input | 1 | Serial data in, sampled on rising serial clock |
| frame_i | input | 1 | Frame select, active high; its fall latches the word |
| sdo_o | output | 1 | Serial data out for cascading |
| cmd_o | output | CMD_W | Held command word |
| upd_o | output | 1 | One-cycle strobe marking a new held command |

## Verification
The assertions assume that each serial clock half period lasts well beyond the synchronizer latency. They also assume that serial data is stable around each rising serial clock edge, and that the frame select never moves in the same few system cycles as a serial clock edge. Under these conditions, every edge arrives as one isolated event in the system domain. The stimulus keeps every serial phase 20 system cycles long. Data changes only while the serial clock is low. The bench also leaves a full half period between the frame select and the nearest serial clock edge, both for random-length frames and for bursts of clocks outside a frame.

// File: rtl/scmd_pkg.sv
package scmd_pkg;

    // Positions of the asynchronous inputs inside the synchronizer bundle
    localparam int SIG_SCLK  = 0;
    localparam int SIG_SDI   = 1;
    localparam int SIG_FRAME = 2;
    localparam int SIG_COUNT = 3;

    // Edge events produced for one synchronized signal
    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

endpackage

// File: rtl/scmd_sync.sv
module scmd_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_q [STAGES];
    logic [WIDTH-1:0] stage_d [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_i;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage_q[s] <= '0;
                end else begin
                    stage_q[s] <= stage_d[s];
                end
            end
        end
    endgenerate

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/scmd_edge.sv
module scmd_edge
    import scmd_pkg::*;
#(
    parameter int WIDTH = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [WIDTH-1:0]     lvl_i,
    output edge_ev_t [WIDTH-1:0] ev_o
);

    logic [WIDTH-1:0] prev_d, prev_q;

    always_comb prev_d = lvl_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= prev_d;
        end
    end

    genvar b;
    generate
        for (b = 0; b < WIDTH; b++) begin : g_bit
            assign ev_o[b].rise = lvl_i[b] & ~prev_q[b];
            assign ev_o[b].fall = ~lvl_i[b] & prev_q[b];
        end
    endgenerate

endmodule

// File: rtl/scmd_shifter.sv
module scmd_shifter #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_i,
    input  logic         frame_rise_i,
    input  logic         sclk_rise_i,
    input  logic         sclk_fall_i,
    input  logic         sdi_i,
    output logic [W-1:0] word_o,
    output logic         sdo_o
);

    typedef struct packed {
        logic [W-1:0] sr;
        logic         so;
    } sh_state_t;

    sh_state_t d, q;

    always_comb begin
        d = q;
        if (frame_i && sclk_rise_i) begin
            d.sr = {q.sr[W-2:0], sdi_i};
        end
        if (frame_rise_i || (frame_i && sclk_fall_i)) begin
            d.so = q.sr[W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign word_o = q.sr;
    assign sdo_o  = q.so;

    AST_SHIFT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_i |=> $stable(q.sr)); // R3

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_i && sclk_rise_i) |=> (q.sr[0] == $past(sdi_i))); // R2

    AST_SDO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!frame_rise_i && !(frame_i && sclk_fall_i)) |=> $stable(q.so)); // R7

endmodule

// File: rtl/scmd_hold.sv
module scmd_hold #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_fall_i,
    input  logic [W-1:0] word_i,
    output logic [W-1:0] cmd_o,
    output logic         upd_o
);

    typedef struct packed {
        logic [W-1:0] cmd;
        logic         stb;
    } hold_state_t;

    hold_state_t d, q;

    always_comb begin
        d     = q;
        d.stb = frame_fall_i;
        if (frame_fall_i) begin
            d.cmd = word_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cmd_o = q.cmd;
    assign upd_o = q.stb;

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        q.stb |=> !q.stb); // R5

    AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_fall_i |=> $stable(q.cmd)); // R4

endmodule

// File: rtl/scmd_chain_reg.sv
module scmd_chain_reg
    import scmd_pkg::*;
#(
    parameter int CMD_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             sclk_i,
    input  logic             sdi_i,
    input  logic             frame_i,
    output logic             sdo_o,
    output logic [CMD_W-1:0] cmd_o,
    output logic             upd_o
);

    logic [SIG_COUNT-1:0]     raw_bus, sync_bus;
    edge_ev_t [SIG_COUNT-1:0] ev;
    logic [CMD_W-1:0]         shift_word;

    assign raw_bus[SIG_SCLK]  = sclk_i;
    assign raw_bus[SIG_SDI]   = sdi_i;
    assign raw_bus[SIG_FRAME] = frame_i;

    scmd_sync #(
        .WIDTH  (SIG_COUNT),
        .STAGES (SYNC_STAGES)
    ) sync_u (
        .clk     (clk),
        .rst_n   (por_n),
        .async_i (raw_bus),
        .sync_o  (sync_bus)
    );

    scmd_edge #(
        .WIDTH (SIG_COUNT)
    ) edge_u (
        .clk   (clk),
        .rst_n (por_n),
        .lvl_i (sync_bus),
        .ev_o  (ev)
    );

    scmd_shifter #(
        .W (CMD_W)
    ) shift_u (
        .clk          (clk),
        .rst_n        (por_n),
        .frame_i      (sync_bus[SIG_FRAME]),
        .frame_rise_i (ev[SIG_FRAME].rise),
        .sclk_rise_i  (ev[SIG_SCLK].rise),
        .sclk_fall_i  (ev[SIG_SCLK].fall),
        .sdi_i        (sync_bus[SIG_SDI]),
        .word_o       (shift_word),
        .sdo_o        (sdo_o)
    );

    scmd_hold #(
        .W (CMD_W)
    ) hold_u (
        .clk          (clk),
        .rst_n        (por_n),
        .frame_fall_i (ev[SIG_FRAME].fall),
        .word_i       (shift_word),
        .cmd_o        (cmd_o),
        .upd_o        (upd_o)
    );

    AST_STROBE_MATCH: assert property (@(posedge clk) disable iff (!por_n)
        upd_o |-> (cmd_o == $past(shift_word))); // R5

    AST_RESET_IDLE: assert property (@(posedge clk)
        !por_n |=> (cmd_o == '0 && !upd_o && !sdo_o)); // R1

endmodule

// File: tb/scmd_chain_reg_tb_top.sv
module scmd_chain_reg_tb_top;

    localparam int W  = 10;
    localparam int HP = 20;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic frame = 1'b0;
    logic sdo_h, sdo_t, upd_h, upd_t;
    logic [W-1:0] cmd_h, cmd_t;
    logic [W-1:0] m_h = '0;
    logic [W-1:0] m_t = '0;
    int total = 0;
    int bad = 0;
    int cyc = 0;

    always #5 clk = ~clk;

    scmd_chain_reg #(.CMD_W(W), .SYNC_STAGES(2)) dut_i (
        .clk(clk), .por_n(por_n), .sclk_i(sclk), .sdi_i(sdi), .frame_i(frame),
        .sdo_o(sdo_h), .cmd_o(cmd_h), .upd_o(upd_h));

    scmd_chain_reg #(.CMD_W(W), .SYNC_STAGES(2)) tail_i (
        .clk(clk), .por_n(por_n), .sclk_i(sclk), .sdi_i(sdo_h), .frame_i(frame),
        .sdo_o(sdo_t), .cmd_o(cmd_t), .upd_o(upd_t));

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL watchdog: run hung, actual cycles=%0d expected below 150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [W-1:0] shift_in(input logic [W-1:0] r, input logic b);
        return {r[W-2:0], b};
    endfunction

    // One frame of n bits, sent from bit n-1 down to bit 0
    task automatic run_frame(input logic [63:0] bits, input int n);
        logic [W-1:0] prev_h;
        int cnt_h;
        int cnt_t;
        string tag;
        prev_h = cmd_h;
        frame = 1'b1;
        cycles(HP);
        for (int i = n - 1; i >= 0; i--) begin
            sdi = bits[i];
            cycles(HP);
            check("R6 sdo bit", {31'd0, sdo_h}, {31'd0, m_h[W-1]});
            check("R4 cmd stable", {22'd0, cmd_h}, {22'd0, prev_h});
            m_t = shift_in(m_t, m_h[W-1]);
            m_h = shift_in(m_h, bits[i]);
            sclk = 1'b1;
            cycles(HP);
            sclk = 1'b0;
        end
        cycles(HP);
        frame = 1'b0;
        cnt_h = 0;
        cnt_t = 0;
        for (int k = 0; k < 12; k++) begin
            @(negedge clk);
            if (upd_h) cnt_h++;
            if (upd_t) cnt_t++;
        end
        check("R5 strobe count", cnt_h, 1);
        check("R5 tail strobe count", cnt_t, 1);
        if (n == 0)       tag = "R3 empty frame";
        else if (n == W)  tag = "R2 word";
        else              tag = "R8 partial word";
        check(tag, {22'd0, cmd_h}, {22'd0, m_h});
        check("R9 tail word", {22'd0, cmd_t}, {22'd0, m_t});
        cycles(HP);
    endtask

    // Serial clocks with the frame low must be ignored
    task automatic idle_clocks(input int k);
        logic [W-1:0] prev_h;
        prev_h = cmd_h;
        for (int i = 0; i < k; i++) begin
            sdi = 1'($urandom());
            cycles(HP);
            sclk = 1'b1;
            cycles(HP);
            sclk = 1'b0;
            check("R3 no strobe", {31'd0, upd_h}, 32'd0);
        end
        cycles(HP);
        check("R3 cmd kept", {22'd0, cmd_h}, {22'd0, prev_h});
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        cycles(4);
        check("R1 cmd in reset", {22'd0, cmd_h}, 32'd0);
        por_n = 1'b1;
        cycles(3);
        check("R1 cmd", {22'd0, cmd_h}, 32'd0);
        check("R1 strobe", {31'd0, upd_h}, 32'd0);
        check("R1 sdo", {31'd0, sdo_h}, 32'd0);

        run_frame(64'h3FF, W);
        run_frame(64'h200, W);
        idle_clocks(5);
        run_frame(64'h0, 0);
        run_frame(64'h1AB5, 13);
        run_frame(64'h5A5C3, 20);
        run_frame(64'h2, 3);

        for (int f = 0; f < 24; f++) begin
            logic [63:0] v;
            int n;
            v = {$urandom(), $urandom()};
            n = int'($urandom_range(0, 25));
            if (f % 3 == 0) n = W;
            if (f % 5 == 1) n = 2 * W;
            run_frame(v, n);
            if (f % 7 == 3) idle_clocks(int'($urandom_range(1, 4)));
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule